// File: doc/BRIEF.md
# Dual-Channel Prescaled Interval Timer

This block is a register-mapped timer with two identical 16-bit counting channels. Both channels run from one functional clock, and each channel applies its own power-of-two prescaler to it. Software sets up a channel by writing a terminal value and a control word over a simple 16-bit register bus. The channel then counts up from zero, once per prescaled tick. When the count meets the terminal value, the channel latches a pending flag. Depending on its mode it then wraps to zero and keeps going (auto-reload), or it stops by itself (one-shot). The pending flag, gated by a per-channel interrupt enable, drives that channel's interrupt output. Software acknowledges the interrupt by writing 1 to the flag.

Each channel is built around a two-state machine, `ch_state_t`:

- **CH_STOP**: the counter is frozen and the prescaler divider is held at zero.
- **CH_COUNT**: the counter advances on every prescaled tick.

The transitions between the states are:

- **START** (CH_STOP to CH_COUNT): a control write with the run bit set. It clears the counter.
- **HALT** (CH_COUNT to CH_STOP): a control write with the run bit clear.
- **EXPIRE** (CH_COUNT to CH_STOP): the terminal tick in one-shot mode. It clears the run bit.
- **WRAP** (CH_COUNT to CH_COUNT): the terminal tick in auto-reload mode. The counter returns to 0.

Top module: `dual_ivl_timer`

## Requirements
- R1: After reset, every register of both channels reads 0, both channels are in CH_STOP, and `irq` is 0.
- R2: Channel n (n = 0, 1) has its register group at byte address 0x80 + n*0x80. Within the group, the control register is at +0x0, the status register at +0x4, the terminal (load) register at +0x8 and the count register at +0xC. A read of any other address returns 0, and a write to any other address changes nothing.
- R3: The control register fields are: bit 8 interrupt enable, bit 5 run, bit 4 one-shot (1 means one-shot, 0 means auto-reload), and bits 3:0 prescale code. All other control bits read back as 0. The load register reads back the value written to it.
- R4: A prescale code c from 0 to 8 produces one tick every 2^c clock cycles. Codes 9 to 15 divide by 256, and they read back unchanged.
- R5: START clears the count to 0 and begins a full prescaled period. After k clock edges from the START edge, the count reads floor(k / 2^c).
- R6: In auto-reload mode, a tick that arrives while count equals load is the WRAP. The count becomes 0, the pending flag is set and the run bit stays 1. With load 0xFFFF, the count passes through all 65536 values.
- R7: In one-shot mode, the terminal tick is the EXPIRE. The count becomes 0, the pending flag is set, the run bit reads 0, and the count stays 0 afterwards.
- R8: HALT freezes the count at its current value and resets the prescaler divider, so a later START waits a whole 2^c cycles before the first tick.
- R9: Status bit 0 is the pending flag. Writing 1 to it clears the flag, and writing 0 has no effect. The flag is set even when the interrupt is disabled. `irq[n]` equals the flag of channel n ANDed with its interrupt enable.
- R10: The two channels count independently of each other, each with its own code, mode and load value.
- R11: Reads are combinational. `bus_rdata` reflects the addressed register in the same cycle that `bus_sel` is high with `bus_wr` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock shared by both channels |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational; 0 when not selected or unmapped |
| irq | output | 2 | Per-channel interrupt, bit n for channel n |

## Verification
A register write takes effect at the rising edge that samples it. A read returns its value in the same cycle, so the bench reads in the low phase without spending an edge. From a START edge, the count is due at floor(k/2^c) after k further edges. The pending flag, the wrap to zero and the interrupt are due on exactly the (load+1)*2^c-th edge, and HALT takes effect on its own write edge. Every directed task counts edges from its own write, and it samples at the falling edge one edge before each predicted change and again at that change. A result that arrives one cycle early or late is therefore caught.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    localparam int REG_W    = 16;
    localparam int CODE_W   = 4;
    localparam int GRP_LSB  = 7;

    localparam int IE_BIT   = 8;
    localparam int RUN_BIT  = 5;
    localparam int OS_BIT   = 4;
    localparam int PEND_BIT = 0;

    localparam logic [GRP_LSB-1:0] OFS_CTRL = 7'h00;
    localparam logic [GRP_LSB-1:0] OFS_STAT = 7'h04;
    localparam logic [GRP_LSB-1:0] OFS_LOAD = 7'h08;
    localparam logic [GRP_LSB-1:0] OFS_CNT  = 7'h0C;

    typedef enum logic {
        CH_STOP  = 1'b0,
        CH_COUNT = 1'b1
    } ch_state_t;

endpackage

// File: rtl/ivt_prescaler.sv
module ivt_prescaler #(
    parameter int CODE_W   = 4,
    parameter int MAX_CODE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              tick_o
);

    localparam int DIV_W = (MAX_CODE < 1) ? 1 : MAX_CODE;

    logic [CODE_W-1:0] eff_code;
    logic [DIV_W-1:0]  limit;
    logic [DIV_W-1:0]  div_q;

    always_comb begin
        eff_code = (code_i > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code_i;
        limit    = DIV_W'((32'd1 << eff_code) - 32'd1);
        tick_o   = run_i && (div_q >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!run_i || tick_o) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // R4: a divide above 1 never produces two ticks back to back
    p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && limit != '0) |=> (!tick_o || code_i != $past(code_i)));

    // R8: a stopped channel leaves its divider at zero
    p_div_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (div_q == '0));

endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
    import ivt_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int MAX_CODE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl_i,
    input  logic             wr_stat_i,
    input  logic             wr_load_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] ctrl_o,
    output logic [REG_W-1:0] stat_o,
    output logic [REG_W-1:0] load_o,
    output logic [REG_W-1:0] count_o,
    output logic             irq_o
);

    ch_state_t         state_q, state_d;
    logic              ie_q, os_q, pend_q;
    logic [CODE_W-1:0] code_q;
    logic [CNT_W-1:0]  load_q, count_q;
    logic              tick_w, term_w, start_w, halt_w;

    ivt_prescaler #(
        .CODE_W   (CODE_W),
        .MAX_CODE (MAX_CODE)
    ) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state_q == CH_COUNT),
        .code_i (code_q),
        .tick_o (tick_w)
    );

    always_comb begin
        start_w = wr_ctrl_i && wdata_i[RUN_BIT] && (state_q == CH_STOP);
        halt_w  = wr_ctrl_i && !wdata_i[RUN_BIT];
        term_w  = tick_w && (count_q == load_q);
    end

    // next-state: START, HALT, EXPIRE, WRAP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_STOP: begin
                if (start_w) state_d = CH_COUNT;
            end
            CH_COUNT: begin
                if (halt_w)              state_d = CH_STOP;
                else if (term_w && os_q) state_d = CH_STOP;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_STOP;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q    <= 1'b0;
            os_q    <= 1'b0;
            code_q  <= '0;
            load_q  <= '0;
            count_q <= '0;
            pend_q  <= 1'b0;
        end else begin
            if (wr_ctrl_i) begin
                ie_q   <= wdata_i[IE_BIT];
                os_q   <= wdata_i[OS_BIT];
                code_q <= wdata_i[CODE_W-1:0];
            end
            if (wr_load_i) load_q <= CNT_W'(wdata_i);
            if (start_w) begin
                count_q <= '0;
            end else if (tick_w) begin
                count_q <= term_w ? '0 : count_q + 1'b1;
            end
            if (term_w) begin
                pend_q <= 1'b1;
            end else if (wr_stat_i && wdata_i[PEND_BIT]) begin
                pend_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        ctrl_o              = '0;
        ctrl_o[IE_BIT]      = ie_q;
        ctrl_o[RUN_BIT]     = (state_q == CH_COUNT);
        ctrl_o[OS_BIT]      = os_q;
        ctrl_o[CODE_W-1:0]  = code_q;
        stat_o              = '0;
        stat_o[PEND_BIT]    = pend_q;
        load_o              = REG_W'(load_q);
        count_o             = REG_W'(count_q);
        irq_o               = pend_q && ie_q;
    end

    // R5: START restarts at zero in CH_COUNT
    p_start_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_w |=> (count_q == '0 && state_q == CH_COUNT));

    // R6: the terminal tick latches the pending flag
    p_term_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
        term_w |=> pend_q);

    // R6: WRAP keeps counting from zero
    p_wrap_runs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (term_w && !os_q && !wr_ctrl_i) |=> (state_q == CH_COUNT && count_q == '0));

    // R7: EXPIRE stops the channel
    p_expire_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (term_w && os_q) |=> (state_q == CH_STOP));

    // R8: a stopped channel keeps its count
    p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_STOP && !start_w) |=> $stable(count_q));

endmodule

// File: rtl/dual_ivl_timer.sv
module dual_ivl_timer
    import ivt_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int ADDR_W   = 12,
    parameter int CNT_W    = 16,
    parameter int MAX_CODE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] irq
);

    localparam int IDX_W = ADDR_W - GRP_LSB;

    logic [IDX_W-1:0]   grp_idx;
    logic [GRP_LSB-1:0] grp_ofs;
    logic [NUM_CH-1:0]  reg_hit;
    logic [NUM_CH-1:0][REG_W-1:0] rd_w;

    assign grp_idx = bus_addr[ADDR_W-1:GRP_LSB];
    assign grp_ofs = bus_addr[GRP_LSB-1:0];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic             grp_hit;
        logic [REG_W-1:0] ctrl_v, stat_v, load_v, cnt_v, rd_v;

        assign grp_hit = bus_sel && (grp_idx == IDX_W'(g + 1));

        ivt_channel #(
            .CNT_W    (CNT_W),
            .MAX_CODE (MAX_CODE)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_ctrl_i (grp_hit && bus_wr && grp_ofs == OFS_CTRL),
            .wr_stat_i (grp_hit && bus_wr && grp_ofs == OFS_STAT),
            .wr_load_i (grp_hit && bus_wr && grp_ofs == OFS_LOAD),
            .wdata_i   (bus_wdata),
            .ctrl_o    (ctrl_v),
            .stat_o    (stat_v),
            .load_o    (load_v),
            .count_o   (cnt_v),
            .irq_o     (irq[g])
        );

        always_comb begin
            rd_v = '0;
            if (grp_hit && !bus_wr) begin
                case (grp_ofs)
                    OFS_CTRL: rd_v = ctrl_v;
                    OFS_STAT: rd_v = stat_v;
                    OFS_LOAD: rd_v = load_v;
                    OFS_CNT:  rd_v = cnt_v;
                    default:  rd_v = '0;
                endcase
            end
        end

        assign reg_hit[g] = grp_hit && (grp_ofs == OFS_CTRL || grp_ofs == OFS_STAT ||
                                        grp_ofs == OFS_LOAD || grp_ofs == OFS_CNT);
        assign rd_w[g]    = rd_v;
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) bus_rdata |= rd_w[i];
    end

    // R2: unmapped reads return zero
    p_undef_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && reg_hit == '0) |-> (bus_rdata == '0));

endmodule

// File: tb/test_dual_ivl_timer.sv
`timescale 1ns/1ps
module test_dual_ivl_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    dual_ivl_timer i_dual_ivl_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #0.1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rchk(input string tag, input logic [11:0] a, input logic [15:0] exp);
        logic [15:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    task automatic t_reset;
        rchk("R1 ch0 ctrl", 12'h080, 16'h0000);
        rchk("R1 ch0 stat", 12'h084, 16'h0000);
        rchk("R1 ch0 load", 12'h088, 16'h0000);
        rchk("R1 ch1 count", 12'h10C, 16'h0000);
        chk("R1 irq", {14'b0, irq}, 16'h0000);
    endtask

    task automatic t_fields;
        wr(12'h100, 16'hFFDF);
        rchk("R3 ctrl unused bits", 12'h100, 16'h011F);
        chk("R3 irq idle", {14'b0, irq}, 16'h0000);
        wr(12'h100, 16'h0000);
        rchk("R3 ctrl cleared", 12'h100, 16'h0000);
        wr(12'h088, 16'hA5A5);
        rchk("R11 load readback", 12'h088, 16'hA5A5);
    endtask

    task automatic t_reload;
        wr(12'h088, 16'h0004);
        wr(12'h080, 16'h0120);
        idle(4);
        rchk("R6 count before wrap", 12'h08C, 16'h0004);
        rchk("R6 no pend before wrap", 12'h084, 16'h0000);
        idle(1);
        rchk("R6 count wrapped", 12'h08C, 16'h0000);
        rchk("R6 pend set", 12'h084, 16'h0001);
        rchk("R6 run kept", 12'h080, 16'h0120);
        chk("R9 irq ch0", {14'b0, irq}, 16'h0001);
        idle(2);
        rchk("R5 count after wrap", 12'h08C, 16'h0002);
        wr(12'h084, 16'h0000);
        rchk("R9 write 0 keeps pend", 12'h084, 16'h0001);
        wr(12'h084, 16'h0001);
        rchk("R9 write 1 clears", 12'h084, 16'h0000);
        chk("R9 irq cleared", {14'b0, irq}, 16'h0000);
        wr(12'h080, 16'h0100);
        rchk("R8 halt on terminal edge", 12'h08C, 16'h0000);
        wr(12'h084, 16'h0001);
        rchk("R9 final clear", 12'h084, 16'h0000);
    endtask

    task automatic t_prescale;
        wr(12'h088, 16'hFFFF);
        wr(12'h080, 16'h0022);
        idle(11);
        rchk("R4 div4 k=11", 12'h08C, 16'h0002);
        idle(1);
        rchk("R4 div4 k=12", 12'h08C, 16'h0003);
        wr(12'h080, 16'h0000);
        wr(12'h080, 16'h002C);
        rchk("R4 code 12 readback", 12'h080, 16'h002C);
        idle(255);
        rchk("R4 code 12 k=255", 12'h08C, 16'h0000);
        idle(1);
        rchk("R4 code 12 k=256", 12'h08C, 16'h0001);
        wr(12'h080, 16'h0000);
    endtask

    task automatic t_halt;
        wr(12'h080, 16'h0023);
        idle(20);
        rchk("R5 div8 k=20", 12'h08C, 16'h0002);
        wr(12'h080, 16'h0003);
        rchk("R8 halted count", 12'h08C, 16'h0002);
        idle(10);
        rchk("R8 frozen", 12'h08C, 16'h0002);
        wr(12'h080, 16'h0023);
        rchk("R5 restart zero", 12'h08C, 16'h0000);
        idle(7);
        rchk("R8 divider reset k=7", 12'h08C, 16'h0000);
        idle(1);
        rchk("R8 divider reset k=8", 12'h08C, 16'h0001);
        wr(12'h080, 16'h0000);
    endtask

    task automatic t_oneshot;
        wr(12'h108, 16'h0003);
        wr(12'h100, 16'h0031);
        idle(7);
        rchk("R7 count before expire", 12'h10C, 16'h0003);
        rchk("R7 run before expire", 12'h100, 16'h0031);
        idle(1);
        rchk("R7 count expired", 12'h10C, 16'h0000);
        rchk("R7 pend", 12'h104, 16'h0001);
        rchk("R7 run cleared", 12'h100, 16'h0011);
        chk("R9 masked irq", {14'b0, irq}, 16'h0000);
        idle(20);
        rchk("R7 stays stopped", 12'h10C, 16'h0000);
        wr(12'h100, 16'h0110);
        chk("R9 unmask irq ch1", {14'b0, irq}, 16'h0002);
        wr(12'h104, 16'h0001);
        chk("R9 ack ch1", {14'b0, irq}, 16'h0000);
        wr(12'h100, 16'h0000);
    endtask

    task automatic t_indep;
        wr(12'h088, 16'hFFFF);
        wr(12'h108, 16'hFFFF);
        wr(12'h080, 16'h0020);
        wr(12'h100, 16'h0021);
        idle(9);
        rchk("R10 ch0 count", 12'h08C, 16'h000A);
        rchk("R10 ch1 count", 12'h10C, 16'h0004);
        wr(12'h080, 16'h0000);
        wr(12'h100, 16'h0000);
    endtask

    task automatic t_undef;
        wr(12'h088, 16'h1234);
        wr(12'h080, 16'h0007);
        rchk("R2 read 0x000", 12'h000, 16'h0000);
        rchk("R2 read 0x090", 12'h090, 16'h0000);
        rchk("R2 read 0x180", 12'h180, 16'h0000);
        rchk("R2 read 0x08E", 12'h08E, 16'h0000);
        wr(12'h010, 16'hFFFF);
        wr(12'h094, 16'hFFFF);
        wr(12'h180, 16'hFFFF);
        rchk("R2 load untouched", 12'h088, 16'h1234);
        rchk("R2 ctrl untouched", 12'h080, 16'h0007);
        rchk("R2 ch1 ctrl untouched", 12'h100, 16'h0000);
        chk("R2 irq untouched", {14'b0, irq}, 16'h0000);
        wr(12'h080, 16'h0000);
    endtask

    task automatic t_fullrange;
        wr(12'h088, 16'hFFFF);
        wr(12'h080, 16'h0020);
        idle(65535);
        rchk("R6 full range top", 12'h08C, 16'hFFFF);
        rchk("R6 full range no pend", 12'h084, 16'h0000);
        idle(1);
        rchk("R6 full range wrap", 12'h08C, 16'h0000);
        rchk("R6 full range pend", 12'h084, 16'h0001);
        rchk("R6 full range run", 12'h080, 16'h0020);
        idle(1);
        rchk("R6 full range restarts", 12'h08C, 16'h0001);
        wr(12'h080, 16'h0000);
        wr(12'h084, 16'h0001);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(190000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_reload();
        t_prescale();
        t_halt();
        t_oneshot();
        t_indep();
        t_undef();
        t_fullrange();
        finish_run();
    end

endmodule